// File: doc/BRIEF.md
# Four-Stage Sequential Mini Processor

This block is a small multi-cycle register machine. It carries one instruction at a time through four stages in a fixed order: fetch, decode, execute and commit. The next instruction is not fetched until the previous one has committed, so there is no overlap between instructions and no hazard logic. The instruction set is kept small. It holds only the operations needed for a polynomial-evaluation loop: move-immediate, shifted add, multiply, multiply-accumulate, a load that advances its pointer, compare, and branch-if-not-equal. A halt operation ends a run.

A host writes the program into instruction memory through a write port and then pulses `start`. The core fetches from word 0 and reads data words through a word-addressed read port. When it commits a halt it raises `done`. Any register can then be read through a readback port. A later `start` pulse runs the program held in instruction memory again, and the register contents are kept.

Top module: `seq4_core`

## Requirements
- R1: After reset, `stage` reads 0 (idle), `done` is 0, and every one of the sixteen 32-bit registers reads 0. The program counter and the zero flag are cleared.
- R2: Every instruction takes exactly four cycles. `stage` shows 1, 2, 3, 4 (fetch, decode, execute, commit) in that order. If the edge that samples `start` is edge 0 and the run executes N instructions including the halt, `stage` is 5 and `done` is 1 from edge 4N onwards. The instruction word is opcode[15:12], rd[11:8], ra[7:4], rb[3:0], and imm8 is [7:0].
- R3: Opcode 1 (move-immediate) writes imm8, zero-extended, into rd.
- R4: Opcode 2 (shifted add) writes ra + (rd << imm[3:0]) into rd.
- R5: Opcode 3 writes the low 32 bits of ra × rb into rd. Opcode 4 writes ra × rb + rd into rd.
- R6: Opcode 5 (post-indexed load) reads the data word at word address ra[DADDR_W+1:2] during execute. At commit it writes that word to rd and ra + 4 to ra. When rd equals ra, the loaded word is the value kept.
- R7: Opcode 6 sets the zero flag to (ra == rb) and writes no register. Opcode 7 moves the PC to PC + sign-extended imm8 when the flag is clear. When the flag is set, it goes to PC + 1.
- R8: Opcode 15 halts the run. `done` and `stage` = 5 stay until a new `start`. A `start` pulse that arrives while an instruction is in flight has no effect.
- R9: Any other opcode is a no-op. It takes four cycles and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run at instruction 0 when idle or done |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | PC_W | Instruction memory write word address |
| imem_wdata | input | 16 | Instruction word to write |
| dmem_re | output | 1 | Data read strobe, high during execute of a load |
| dmem_addr | output | DADDR_W | Data memory word address |
| dmem_rdata | input | 32 | Data word returned in the same cycle |
| done | output | 1 | High after a halt has committed |
| stage | output | 3 | 0 idle, 1 fetch, 2 decode, 3 execute, 4 commit, 5 done |
| rf_raddr | input | 4 | Register readback index |
| rf_rdata | output | 32 | Register readback value, combinational |

## Verification
The edge that samples `start` is taken as cycle 0. At each negative edge k after it, the bench expects `stage` to equal 1 + (k mod 4) for every k below 4N, and `done` together with stage 5 exactly at k = 4N. N is the instruction count that the bench's own instruction-level interpreter counts for the same program. Register effects are checked only once the run is over, through the readback port, because each instruction's write becomes visible only at its commit edge. Two programs are used: a three-term polynomial loop, and a corner program. The corner program covers an unknown opcode, a load whose destination is also its base, a branch that falls through, a branch that is taken, and a `start` pulse in mid-run.

// File: rtl/seq4_pkg.sv
package seq4_pkg;
    localparam int XLEN   = 32;
    localparam int INSN_W = 16;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [3:0] OP_MOVI  = 4'h1;
    localparam logic [3:0] OP_ADDSH = 4'h2;
    localparam logic [3:0] OP_MUL   = 4'h3;
    localparam logic [3:0] OP_MLA   = 4'h4;
    localparam logic [3:0] OP_LDP   = 4'h5;
    localparam logic [3:0] OP_CMP   = 4'h6;
    localparam logic [3:0] OP_BNE   = 4'h7;
    localparam logic [3:0] OP_HALT  = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_EXEC   = 3'd3,
        ST_COMMIT = 3'd4,
        ST_DONE   = 3'd5
    } stage_e;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] rd;
        logic [3:0] ra;
        logic [3:0] rb;
        logic [7:0] imm8;
    } fields_t;

    typedef struct packed {
        logic wr_main;
        logic wr_base;
        logic set_z;
        logic is_bne;
        logic is_ldp;
        logic is_halt;
    } ctl_t;
endpackage

// File: rtl/seq4_imem.sv
module seq4_imem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/seq4_regfile.sv
module seq4_regfile #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   ra_a,
    input  logic [IW-1:0]   ra_b,
    input  logic [IW-1:0]   ra_c,
    input  logic [IW-1:0]   ra_dbg,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    output logic [XLEN-1:0] rd_c,
    output logic [XLEN-1:0] rd_dbg,
    input  logic            we_main,
    input  logic [IW-1:0]   wa_main,
    input  logic [XLEN-1:0] wd_main,
    input  logic            we_base,
    input  logic [IW-1:0]   wa_base,
    input  logic [XLEN-1:0] wd_base
);
    logic [NREG-1:0][XLEN-1:0] regs_d, regs_q;

    // The main write is applied last, so it wins on an index clash.
    always_comb begin
        regs_d = regs_q;
        if (we_base) regs_d[wa_base] = wd_base;
        if (we_main) regs_d[wa_main] = wd_main;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_a   = regs_q[ra_a];
    assign rd_b   = regs_q[ra_b];
    assign rd_c   = regs_q[ra_c];
    assign rd_dbg = regs_q[ra_dbg];
endmodule

// File: rtl/seq4_decode.sv
module seq4_decode
    import seq4_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output fields_t           f,
    output ctl_t              ctl
);
    always_comb begin
        f.op   = insn[15:12];
        f.rd   = insn[11:8];
        f.ra   = insn[7:4];
        f.rb   = insn[3:0];
        f.imm8 = insn[7:0];
        ctl    = '0;
        unique case (f.op)
            OP_MOVI, OP_ADDSH, OP_MUL, OP_MLA: ctl.wr_main = 1'b1;
            OP_LDP: begin
                ctl.wr_main = 1'b1;
                ctl.wr_base = 1'b1;
                ctl.is_ldp  = 1'b1;
            end
            OP_CMP:  ctl.set_z   = 1'b1;
            OP_BNE:  ctl.is_bne  = 1'b1;
            OP_HALT: ctl.is_halt = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/seq4_exec.sv
module seq4_exec
    import seq4_pkg::*;
#(
    parameter int PC_W = 6
) (
    input  logic [3:0]      op,
    input  logic [7:0]      imm8,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] opc,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic [PC_W-1:0] pc,
    input  logic            z_flag,
    output logic [XLEN-1:0] res_main,
    output logic [XLEN-1:0] res_base,
    output logic            z_new,
    output logic            br_take,
    output logic [PC_W-1:0] br_target
);
    logic [XLEN-1:0] prod;
    logic [XLEN-1:0] offs;
    logic [XLEN-1:0] tsum;

    always_comb begin
        prod = opa * opb;
        unique case (op)
            OP_MOVI:  res_main = {{(XLEN-8){1'b0}}, imm8};
            OP_ADDSH: res_main = opa + (opc << imm8[3:0]);
            OP_MUL:   res_main = prod;
            OP_MLA:   res_main = prod + opc;
            OP_LDP:   res_main = mem_rdata;
            default:  res_main = '0;
        endcase
        res_base  = opa + XLEN'(4);
        z_new     = (opa - opb) == '0;
        offs      = {{(XLEN-8){imm8[7]}}, imm8};
        tsum      = XLEN'(pc) + offs;
        br_target = tsum[PC_W-1:0];
        br_take   = (op == OP_BNE) && !z_flag;
    end
endmodule

// File: rtl/seq4_core.sv
module seq4_core
    import seq4_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DADDR_W    = 8,
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               imem_we,
    input  logic [PC_W-1:0]    imem_waddr,
    input  logic [INSN_W-1:0]  imem_wdata,
    output logic               dmem_re,
    output logic [DADDR_W-1:0] dmem_addr,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               done,
    output logic [2:0]         stage,
    input  logic [RIDX_W-1:0]  rf_raddr,
    output logic [XLEN-1:0]    rf_rdata
);
    typedef struct packed {
        stage_e           stage;
        logic [PC_W-1:0]  pc;
        logic [INSN_W-1:0] ir;
        logic [XLEN-1:0]  opa;
        logic [XLEN-1:0]  opb;
        logic [XLEN-1:0]  opc;
        logic [XLEN-1:0]  res_main;
        logic [XLEN-1:0]  res_base;
        logic             z_new;
        logic             br_take;
        logic [PC_W-1:0]  br_target;
        logic             z;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [INSN_W-1:0] imem_rdata;
    fields_t           f;
    ctl_t              ctl;
    logic [XLEN-1:0]   rf_a, rf_b, rf_c;
    logic [XLEN-1:0]   ex_main, ex_base;
    logic              ex_z, ex_take;
    logic [PC_W-1:0]   ex_target;
    logic              we_main, we_base;
    logic [PC_W-1:0]   pc_w;

    seq4_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSN_W)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (st_q.pc),
        .rdata (imem_rdata)
    );

    seq4_decode u_dec (
        .insn (st_q.ir),
        .f    (f),
        .ctl  (ctl)
    );

    assign we_main = (st_q.stage == ST_COMMIT) && ctl.wr_main;
    assign we_base = (st_q.stage == ST_COMMIT) && ctl.wr_base;

    seq4_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_a    (f.ra),
        .ra_b    (f.rb),
        .ra_c    (f.rd),
        .ra_dbg  (rf_raddr),
        .rd_a    (rf_a),
        .rd_b    (rf_b),
        .rd_c    (rf_c),
        .rd_dbg  (rf_rdata),
        .we_main (we_main),
        .wa_main (f.rd),
        .wd_main (st_q.res_main),
        .we_base (we_base),
        .wa_base (f.ra),
        .wd_base (st_q.res_base)
    );

    seq4_exec #(.PC_W(PC_W)) u_exec (
        .op        (f.op),
        .imm8      (f.imm8),
        .opa       (st_q.opa),
        .opb       (st_q.opb),
        .opc       (st_q.opc),
        .mem_rdata (dmem_rdata),
        .pc        (st_q.pc),
        .z_flag    (st_q.z),
        .res_main  (ex_main),
        .res_base  (ex_base),
        .z_new     (ex_z),
        .br_take   (ex_take),
        .br_target (ex_target)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.stage)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    st_d.stage = ST_FETCH;
                    st_d.pc    = '0;
                end
            end
            ST_FETCH: begin
                st_d.ir    = imem_rdata;
                st_d.stage = ST_DECODE;
            end
            ST_DECODE: begin
                st_d.opa   = rf_a;
                st_d.opb   = rf_b;
                st_d.opc   = rf_c;
                st_d.stage = ST_EXEC;
            end
            ST_EXEC: begin
                st_d.res_main  = ex_main;
                st_d.res_base  = ex_base;
                st_d.z_new     = ex_z;
                st_d.br_take   = ex_take;
                st_d.br_target = ex_target;
                st_d.stage     = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (ctl.set_z) st_d.z = st_q.z_new;
                if (ctl.is_halt) begin
                    st_d.stage = ST_DONE;
                end else begin
                    st_d.stage = ST_FETCH;
                    st_d.pc    = st_q.br_take ? st_q.br_target : st_q.pc + PC_W'(1);
                end
            end
            default: st_d.stage = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dmem_re   = (st_q.stage == ST_EXEC) && ctl.is_ldp;
    assign dmem_addr = st_q.opa[DADDR_W+1:2];
    assign done      = (st_q.stage == ST_DONE);
    assign stage     = st_q.stage;
    assign pc_w      = st_q.pc;
endmodule

// File: rtl/seq4_core_chk.sv
module seq4_core_chk #(
    parameter int PC_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      stage,
    input logic [PC_W-1:0] pc,
    input logic            we_main,
    input logic            we_base,
    input logic            dmem_re,
    input logic            done
);
    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage == 3'd1 |=> stage == 3'd2);
    assert_decode_then_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage == 3'd2 |=> stage == 3'd3);
    assert_exec_then_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage == 3'd3 |=> stage == 3'd4);
    assert_commit_then_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage == 3'd4 |=> (stage == 3'd1 || stage == 3'd5));
    assert_writes_at_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_main || we_base) |-> stage == 3'd4);
    assert_load_in_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |-> stage == 3'd3);
    assert_pc_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd1 || stage == 3'd2 || stage == 3'd3) |=> $stable(pc));
    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind seq4_core seq4_core_chk #(.PC_W(PC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .stage   (stage),
    .pc      (pc_w),
    .we_main (we_main),
    .we_base (we_base),
    .dmem_re (dmem_re),
    .done    (done)
);

// File: tb/seq4_core_test.sv
`timescale 1ns/1ps
module seq4_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [15:0] imem_wdata = '0;
    logic        dmem_re;
    logic [7:0]  dmem_addr;
    logic [31:0] dmem_rdata;
    logic        done;
    logic [2:0]  stage;
    logic [3:0]  rf_raddr = '0;
    logic [31:0] rf_rdata;

    logic [31:0] dmem [256];
    logic [15:0] prog [64];
    logic [31:0] m_rf [16];
    bit          m_z;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    assign dmem_rdata = dmem[dmem_addr];

    seq4_core uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .dmem_re(dmem_re), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .done(done), .stage(stage), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Instruction-level interpreter; returns the number of instructions run.
    task automatic model_run(output int n);
        int pc = 0;
        n = 0;
        while (n < 1000) begin
            logic [15:0] w = prog[pc];
            logic [3:0]  op = w[15:12];
            int rd = int'(w[11:8]);
            int ra = int'(w[7:4]);
            int rb = int'(w[3:0]);
            logic [31:0] a;
            n++;
            if (op == 4'hF) break;
            case (op)
                4'h1: m_rf[rd] = {24'd0, w[7:0]};
                4'h2: m_rf[rd] = m_rf[ra] + (m_rf[rd] << w[3:0]);
                4'h3: m_rf[rd] = m_rf[ra] * m_rf[rb];
                4'h4: m_rf[rd] = m_rf[ra] * m_rf[rb] + m_rf[rd];
                4'h5: begin
                    a = m_rf[ra];
                    m_rf[ra] = a + 32'd4;
                    m_rf[rd] = dmem[a[9:2]];
                end
                4'h6: m_z = (m_rf[ra] == m_rf[rb]);
                default: ;
            endcase
            if (op == 4'h7 && !m_z) pc = (pc + int'($signed(w[7:0]))) & 63;
            else                    pc = (pc + 1) & 63;
        end
    endtask

    task automatic load_prog(int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic run_prog(int n, int pulse_k, string tag);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k <= 4 * n; k++) begin
            if (k < 4 * n) begin
                chk(tag, "stage", 32'(stage), 32'(1 + (k % 4)));
                chk(tag, "done early", 32'(done), 32'd0);
            end else begin
                chk("R2", "final stage", 32'(stage), 32'd5);
                chk("R2", "done at 4N", 32'(done), 32'd1);
            end
            start = (k == pulse_k);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic check_regs(string tag);
        for (int i = 0; i < 16; i++) begin
            rf_raddr = 4'(i);
            #0.1;
            chk(tag, $sformatf("reg %0d", i), rf_rdata, m_rf[i]);
        end
    endtask

    task automatic read_reg(int i, output logic [31:0] v);
        rf_raddr = 4'(i);
        #0.1;
        v = rf_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        int n;
        for (int i = 0; i < 256; i++) dmem[i] = 32'(i * 3 + 100);
        for (int i = 0; i < 64; i++) prog[i] = 16'h0000;
        for (int i = 0; i < 16; i++) m_rf[i] = '0;
        m_z = 1'b0;
        dmem[4] = 32'd7; dmem[5] = 32'd3; dmem[6] = 32'd2;
        dmem[10] = 32'h1234;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R1: reset state
        chk("R1", "stage after reset", 32'(stage), 32'd0);
        chk("R1", "done after reset", 32'(done), 32'd0);
        check_regs("R1");

        // Program 1: three-term polynomial, x = 5, coefficients 7, 3, 2
        prog[0]  = 16'h1310; prog[1]  = 16'h1103; prog[2]  = 16'h1205;
        prog[3]  = 16'h2132; prog[4]  = 16'h1401; prog[5]  = 16'h1000;
        prog[6]  = 16'h5530; prog[7]  = 16'h6013; prog[8]  = 16'h4045;
        prog[9]  = 16'h3424; prog[10] = 16'h70FC; prog[11] = 16'hF000;
        load_prog(12);
        model_run(n);
        chk("R2", "instruction count poly", 32'(n), 32'd22);
        run_prog(n, -1, "R2");
        check_regs("R5");
        read_reg(0, v); chk("R5", "accumulator", v, 32'd72);
        read_reg(4, v); chk("R5", "power term", v, 32'd125);
        read_reg(1, v); chk("R4", "end pointer", v, 32'd28);
        read_reg(3, v); chk("R6", "advanced base", v, 32'd28);
        read_reg(5, v); chk("R6", "last loaded", v, 32'd2);

        // R8: done holds while start stays low
        repeat (3) @(negedge clk);
        chk("R8", "done held", 32'(done), 32'd1);
        chk("R8", "stage held", 32'(stage), 32'd5);

        // Program 2: corner cases, with a start pulse in mid-run
        prog[0] = 16'h16FF; prog[1] = 16'hC6FF; prog[2] = 16'h1728;
        prog[3] = 16'h5770; prog[4] = 16'h6066; prog[5] = 16'h7002;
        prog[6] = 16'h1809; prog[7] = 16'h6068; prog[8] = 16'h7002;
        prog[9] = 16'h1901; prog[10] = 16'hF000;
        load_prog(11);
        model_run(n);
        chk("R9", "instruction count corner", 32'(n), 32'd10);
        run_prog(n, 9, "R9");
        check_regs("R7");
        read_reg(6, v); chk("R3", "imm 255 zero-extended", v, 32'd255);
        read_reg(6, v); chk("R9", "unknown opcode left reg", v, 32'd255);
        read_reg(7, v); chk("R6", "load wins over base", v, 32'h1234);
        read_reg(8, v); chk("R7", "fallthrough reached", v, 32'd9);
        read_reg(9, v); chk("R7", "taken branch skipped", v, 32'd0);

        finish_up();
    end
endmodule